// File: doc/BRIEF.md
# Cache Control Register with Diagnostic Parity Array

This block holds a cache control register and a small diagnostic data array, both reached over a simple 32-bit register bus with byte addressing. Software uses the array to store and fetch test words. Every array read also computes a parity bit for each byte of the fetched word and latches those four bits into a read-only diagnostic field of the control register. A test routine can therefore check the parity logic by writing known patterns and reading the control register afterwards.

The control register mixes field kinds: plain read/write enables, a parity-error flag that software clears by writing one and a side input sets, and a bit that always reads as one. A second, read-only register carries a break-enable flag. That flag resets to one and drives a halt-enable output. Array writes may be byte, halfword or longword, and the narrow sizes merge into the addressed lanes of the stored word.

Bus map, with AW = $clog2(ROWS)+3: `bus_addr[AW-1]` = 1 selects the array, with row `bus_addr[AW-2:2]` and byte offset `bus_addr[1:0]`. When `bus_addr[AW-1]` = 0, word index `bus_addr[AW-2:2]` selects a register: 0 is the control register, 1 is the break register, and any other index is unmapped. `bus_size` encodes 0 = byte, 1 = halfword, 2 or 3 = longword. Write data is right-justified.

Top module: `cache_diag_ctl`

## Requirements
- R1: After reset the control register reads 0x00000040, the break register reads 0x00000080, `halt_en` is 1, every array row reads 0 and `bus_rvalid` is 0.
- R2: A read request accepted at a clock edge returns its data on `bus_rdata` with `bus_rvalid` = 1 right after that edge. `bus_rvalid` is 0 after any edge without a read request.
- R3: An array read loads control bits 27:24 at the same edge that returns the data. Bit 24 is the XOR of byte 0 (even parity), bit 25 is the XNOR of byte 1 (odd parity), bit 26 is the XOR of byte 2 and bit 27 is the XNOR of byte 3.
- R4: Control bits 23:8 always read as zero, and every array read clears them.
- R5: A longword array write (size 2 or 3) replaces the whole row selected by `bus_addr[AW-2:2]`, whatever the byte offset.
- R6: A byte or halfword array write places the low 8 or 16 data bits at bit position `bus_addr[1:0]`×8. The other bytes of the row are kept, and data bits that would land above bit 31 are dropped.
- R7: A control register write at byte offset 0 replaces bits 0 (diagnostic mode), 1 (write wrong parity), 2 (parity disable) and 4 (enable) with the data. It leaves bits 27:24 unchanged, keeps bit 6 at one, and leaves bits 3, 7 and 31:28 at zero.
- R8: Control bit 5 (parity error) is cleared by a write at offset 0 whose data has bit 5 set. A write with data bit 5 clear keeps it.
- R9: `perr_set` high at an edge sets bit 5. When a same-cycle write asks to clear the bit, the set wins.
- R10: A control register write at a nonzero byte offset leaves the register unchanged.
- R11: The break register ignores writes and keeps reading 0x00000080, and `halt_en` stays 1.
- R12: An unmapped register word reads 0, and writing it changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | $clog2(ROWS)+3 | Byte address |
| bus_size | input | 2 | 0 byte, 1 halfword, 2/3 longword |
| bus_wdata | input | 32 | Right-justified write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| perr_set | input | 1 | Sets the parity-error flag |
| halt_en | output | 1 | Break-enable flag of the break register |

## Verification
The bench builds the block with ROWS = 4, which makes every row and every register word reachable by a short address sweep. With this size the bench can run all 256 values through each byte lane of an array word and check the latched parity bits against a count of ones for every value. It also tries each combination of access size and byte offset on the merge path, including the halfword at offset 3 whose upper byte falls off the word.

// File: rtl/cache_diag_ctl_pkg.sv
package cache_diag_ctl_pkg;

  localparam logic [31:0] CTRL_RESET  = 32'h0000_0040;
  localparam logic [31:0] CTRL_IMPL   = 32'h0FFF_FF77;
  localparam logic [31:0] BRK_RESET   = 32'h0000_0080;
  localparam int          PERR_BIT    = 5;
  localparam int          FIXED_BIT   = 6;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_LONG  = 2'd2,
    SZ_LONGX = 2'd3
  } acc_size_e;

  // Parity of each byte lane: even lanes XOR, odd lanes XNOR.
  function automatic logic [3:0] lane_parity(input logic [31:0] w);
    logic [3:0] p;
    for (int k = 0; k < 4; k++) begin
      p[k] = ^w[8*k +: 8];
      if (k % 2 == 1) p[k] = ~p[k];
    end
    return p;
  endfunction

  // Merge right-justified data into a stored word.
  function automatic logic [31:0] lane_merge(input logic [31:0] old_w,
                                             input logic [31:0] data,
                                             input logic [1:0]  size,
                                             input logic [1:0]  off);
    logic [31:0] mask;
    logic [4:0]  sh;
    if (size[1]) return data;
    mask = (size == SZ_BYTE) ? 32'h0000_00FF : 32'h0000_FFFF;
    sh   = {off, 3'b000};
    return (old_w & ~(mask << sh)) | ((data & mask) << sh);
  endfunction

endpackage

// File: rtl/cdc_decode.sv
module cdc_decode #(
  parameter int ROWS = 16
) (
  input  logic                      req,
  input  logic                      we,
  input  logic [$clog2(ROWS)+2:0]   addr,
  output logic                      arr_rd,
  output logic                      arr_wr,
  output logic                      ctrl_rd,
  output logic                      ctrl_wr,
  output logic                      brk_rd,
  output logic [$clog2(ROWS)-1:0]   row,
  output logic [1:0]                off
);
  localparam int RW = $clog2(ROWS);
  localparam int AW = RW + 3;

  logic          in_arr;
  logic [RW-1:0] word_idx;

  always_comb begin
    in_arr   = addr[AW-1];
    word_idx = addr[AW-2:2];
    row      = word_idx;
    off      = addr[1:0];
    arr_rd   = req && !we && in_arr;
    arr_wr   = req &&  we && in_arr;
    ctrl_rd  = req && !we && !in_arr && (word_idx == RW'(0));
    ctrl_wr  = req &&  we && !in_arr && (word_idx == RW'(0));
    brk_rd   = req && !we && !in_arr && (word_idx == RW'(1));
  end

endmodule

// File: rtl/cdc_diag_array.sv
module cdc_diag_array
  import cache_diag_ctl_pkg::*;
#(
  parameter int ROWS = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [$clog2(ROWS)-1:0] row,
  input  logic [1:0]              off,
  input  logic [1:0]              size,
  input  logic [31:0]             wdata,
  output logic [31:0]             rd_word,
  output logic [3:0]              rd_par
);
  localparam int RW = $clog2(ROWS);

  logic [31:0] mem [ROWS];
  logic        row_ok;
  logic [31:0] merged;

  always_comb begin
    row_ok  = int'(row) < ROWS;
    rd_word = row_ok ? mem[row] : 32'h0;
    rd_par  = lane_parity(rd_word);
    merged  = lane_merge(rd_word, wdata, size, off);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) mem[i] <= 32'h0;
    end else if (wr_en && row_ok) begin
      mem[row] <= merged;
    end
  end

  // R5: a longword write stores the data exactly
  assert_long_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && size[1] && row_ok) |=> (mem[$past(row)] == $past(wdata)));

  // R6: a byte write at offset 0 keeps the upper three bytes
  assert_byte_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && size == SZ_BYTE && off == 2'd0 && row_ok)
      |=> (mem[$past(row)][31:8] == $past(rd_word[31:8])));

endmodule

// File: rtl/cdc_ctrl_reg.sv
module cdc_ctrl_reg
  import cache_diag_ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        off_zero,
  input  logic [3:0]  wr_keep,
  input  logic        wr_clr,
  input  logic        diag_load,
  input  logic [3:0]  diag_par,
  input  logic        perr_set,
  output logic [31:0] ctrl_q
);
  logic [31:0] nxt;
  logic        wr_take;

  always_comb begin
    wr_take = wr_en && off_zero;
    nxt     = ctrl_q;
    if (diag_load) begin
      nxt[23:8]  = 16'h0;
      nxt[27:24] = diag_par;
    end
    if (wr_take) begin
      if (wr_clr) nxt[PERR_BIT] = 1'b0;
      nxt[FIXED_BIT] = 1'b1;
      nxt[2:0]       = wr_keep[2:0];
      nxt[4]         = wr_keep[3];
    end
    if (perr_set) nxt[PERR_BIT] = 1'b1;
    nxt = (nxt & CTRL_IMPL) | CTRL_RESET;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= CTRL_RESET;
    else        ctrl_q <= nxt;
  end

  // R3: parity from the array is latched at the read edge
  assert_parity_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    diag_load |=> (ctrl_q[27:24] == $past(diag_par)));

  // R7: writable fields follow the data and the fixed bit stays one
  assert_write_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> (ctrl_q[FIXED_BIT] && {ctrl_q[4], ctrl_q[2:0]} == $past(wr_keep)));

  // R8: write-one-to-clear of the parity-error flag
  assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_take && wr_clr && !perr_set) |=> !ctrl_q[PERR_BIT]);

  // R9: the side input sets the flag and wins over a clear
  assert_perr_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    perr_set |=> ctrl_q[PERR_BIT]);

  // R10: writes at a nonzero offset are dropped
  assert_offset_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !off_zero && !perr_set && !diag_load) |=> $stable(ctrl_q));

endmodule

// File: rtl/cache_diag_ctl.sv
module cache_diag_ctl
  import cache_diag_ctl_pkg::*;
#(
  parameter int ROWS = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_req,
  input  logic                    bus_we,
  input  logic [$clog2(ROWS)+2:0] bus_addr,
  input  logic [1:0]              bus_size,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic                    bus_rvalid,
  input  logic                    perr_set,
  output logic                    halt_en
);
  localparam int RW = $clog2(ROWS);

  // Named internal events
  logic          diag_rd_ev, arr_wr_ev, ctrl_rd_ev, ctrl_wr_ev, brk_rd_ev;
  logic          any_rd_ev;
  logic [RW-1:0] row;
  logic [1:0]    off;
  logic [31:0]   arr_word;
  logic [3:0]    arr_par;
  logic [31:0]   ctrl_q;
  logic [31:0]   brk_q;
  logic [31:0]   rd_mux;

  cdc_decode #(.ROWS(ROWS)) u_decode (
    .req     (bus_req),
    .we      (bus_we),
    .addr    (bus_addr),
    .arr_rd  (diag_rd_ev),
    .arr_wr  (arr_wr_ev),
    .ctrl_rd (ctrl_rd_ev),
    .ctrl_wr (ctrl_wr_ev),
    .brk_rd  (brk_rd_ev),
    .row     (row),
    .off     (off)
  );

  cdc_diag_array #(.ROWS(ROWS)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (arr_wr_ev),
    .row     (row),
    .off     (off),
    .size    (bus_size),
    .wdata   (bus_wdata),
    .rd_word (arr_word),
    .rd_par  (arr_par)
  );

  cdc_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ctrl_wr_ev),
    .off_zero  (off == 2'd0),
    .wr_keep   ({bus_wdata[4], bus_wdata[2:0]}),
    .wr_clr    (bus_wdata[PERR_BIT]),
    .diag_load (diag_rd_ev),
    .diag_par  (arr_par),
    .perr_set  (perr_set),
    .ctrl_q    (ctrl_q)
  );

  // Break register: read-only from the bus
  always_ff @(posedge clk) begin
    if (!rst_n) brk_q <= BRK_RESET;
    else        brk_q <= brk_q;
  end
  assign halt_en = brk_q[7];

  always_comb begin
    any_rd_ev = bus_req && !bus_we;
    if (diag_rd_ev)      rd_mux = arr_word;
    else if (ctrl_rd_ev) rd_mux = ctrl_q;
    else if (brk_rd_ev)  rd_mux = brk_q;
    else                 rd_mux = 32'h0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= 32'h0;
    end else begin
      bus_rvalid <= any_rd_ev;
      if (any_rd_ev) bus_rdata <= rd_mux;
    end
  end

  // R2: one-cycle read latency
  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    any_rd_ev |=> bus_rvalid);
  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !any_rd_ev |=> !bus_rvalid);

  // R3: the returned word and the latched parity describe the same word
  assert_parity_matches_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    diag_rd_ev |=> (ctrl_q[27:24] == lane_parity(bus_rdata)));

  // R11: the break flag holds through any bus traffic
  assert_halt_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> $stable(halt_en));

endmodule

// File: tb/cache_diag_ctl_bench.sv
`timescale 1ns/1ps
module cache_diag_ctl_bench;
  localparam int ROWS = 4;
  localparam int AW   = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_req = 1'b0, bus_we = 1'b0, perr_set = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [1:0]    bus_size = 2'd0;
  logic [31:0]   bus_wdata = 32'h0;
  logic [31:0]   bus_rdata;
  logic          bus_rvalid, halt_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_mem [ROWS];
  logic [31:0] exp_ctrl;

  always #4 clk = ~clk;

  cache_diag_ctl #(.ROWS(ROWS)) u_cache_diag_ctl (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .perr_set(perr_set), .halt_en(halt_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [AW-1:0] a, input logic [1:0] sz,
                     input logic [31:0] d, input logic pe,
                     output logic [31:0] rd, output logic vld);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_size = sz;
    bus_wdata = d; perr_set = pe;
    @(negedge clk);
    rd = bus_rdata; vld = bus_rvalid;
    bus_req = 1'b0; bus_we = 1'b0; perr_set = 1'b0;
  endtask

  task automatic rd_word(input logic [AW-1:0] a, output logic [31:0] v);
    logic vld;
    cyc(1'b0, a, 2'd2, 32'h0, 1'b0, v, vld);
    chk("R2 rvalid after read", {31'h0, vld}, 32'h1);
  endtask

  task automatic wr_word(input logic [AW-1:0] a, input logic [1:0] sz,
                         input logic [31:0] d, input logic pe);
    logic [31:0] v; logic vld;
    cyc(1'b1, a, sz, d, pe, v, vld);
  endtask

  function automatic logic [AW-1:0] arr_addr(input int r, input int o);
    return AW'(16 + r * 4 + o);
  endfunction

  // Independent parity restatement: count ones per lane.
  function automatic logic [3:0] exp_par(input logic [31:0] w);
    logic [3:0] p;
    for (int k = 0; k < 4; k++) begin
      int ones = $countones(w[8*k +: 8]);
      p[k] = (k % 2 == 0) ? (ones % 2 == 1) : (ones % 2 == 0);
    end
    return p;
  endfunction

  // Independent merge restatement: byte by byte.
  function automatic logic [31:0] exp_merge(input logic [31:0] old_w, input logic [31:0] d,
                                            input int sz, input int o);
    logic [31:0] r = old_w;
    int nb = (sz == 0) ? 1 : 2;
    if (sz >= 2) return d;
    for (int b = 0; b < 4; b++) begin
      int src = b - o;
      if (src >= 0 && src < nb) r[8*b +: 8] = d[8*src +: 8];
    end
    return r;
  endfunction

  task automatic read_row_check(input int r, input string tag);
    logic [31:0] v;
    rd_word(arr_addr(r, 0), v);
    chk({tag, " R2 row data"}, v, exp_mem[r]);
    exp_ctrl = {exp_ctrl[31:28], exp_par(exp_mem[r]), 16'h0, exp_ctrl[7:0]};
    rd_word(AW'(0), v);
    chk({tag, " R3 parity in control"}, v, exp_ctrl);
  endtask

  task automatic ctrl_write(input logic [31:0] d, input logic pe);
    wr_word(AW'(0), 2'd2, d, pe);
    exp_ctrl = (exp_ctrl & ~32'h17) | (d & 32'h17);
    if (d[5]) exp_ctrl[5] = 1'b0;
    if (pe)   exp_ctrl[5] = 1'b1;
    exp_ctrl[6] = 1'b1;
  endtask

  initial begin
    logic [31:0] v;
    logic        vld;
    for (int i = 0; i < ROWS; i++) exp_mem[i] = 32'h0;
    exp_ctrl = 32'h40;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 rvalid at reset", {31'h0, bus_rvalid}, 32'h0);
    chk("R1 halt_en at reset", {31'h0, halt_en}, 32'h1);
    rd_word(AW'(0), v); chk("R1 control reset", v, 32'h40);
    rd_word(AW'(4), v); chk("R1 break reset", v, 32'h80);
    for (int r = 0; r < ROWS; r++) begin
      rd_word(arr_addr(r, 0), v); chk("R1 row reset", v, 32'h0);
    end
    exp_ctrl = {4'h0, exp_par(32'h0), 16'h0, 8'h40};
    @(negedge clk);
    chk("R2 rvalid low when idle", {31'h0, bus_rvalid}, 32'h0);

    // R5: longword writes per row, at varied offsets
    for (int r = 0; r < ROWS; r++) begin
      logic [31:0] d = 32'h1357_9BDF ^ (32'h0101_0101 * (r + 1));
      wr_word(arr_addr(r, r % 4), 2'd2, d, 1'b0);
      exp_mem[r] = d;
    end
    for (int r = 0; r < ROWS; r++) read_row_check(r, "R5");

    // R3, R4: full sweep of each lane through all 256 values
    for (int x = 0; x < 256; x++) begin
      logic [7:0]  b = 8'(x);
      logic [31:0] d = {b, 8'(x * 3), ~b, b ^ 8'hA5};
      wr_word(arr_addr(0, 0), 2'd3, d, 1'b0);
      exp_mem[0] = d;
      read_row_check(0, "R3 sweep");
    end
    rd_word(AW'(0), v);
    chk("R4 bits 23:8 zero", v & 32'h00FF_FF00, 32'h0);

    // R6: byte and halfword merges at every offset
    for (int sz = 0; sz < 2; sz++) begin
      for (int o = 0; o < 4; o++) begin
        logic [31:0] base = 32'hA1B2_C3D4;
        logic [31:0] d    = 32'hFFFF_E65C + 32'(o);
        wr_word(arr_addr(2, 0), 2'd2, base, 1'b0);
        wr_word(arr_addr(2, o), 2'(sz), d, 1'b0);
        exp_mem[2] = exp_merge(base, d, sz, o);
        read_row_check(2, "R6 merge");
      end
    end

    // R7: field writes
    ctrl_write(32'h0000_0017, 1'b0);
    rd_word(AW'(0), v); chk("R7 set fields", v, exp_ctrl);
    ctrl_write(32'hFFFF_FFFF, 1'b0);
    rd_word(AW'(0), v); chk("R7 all-ones write", v, exp_ctrl);
    ctrl_write(32'h0000_0000, 1'b0);
    rd_word(AW'(0), v); chk("R7 zero write", v, exp_ctrl);
    chk("R7 fixed bit", {31'h0, v[6]}, 32'h1);

    // R9: side input sets the flag
    @(negedge clk); perr_set = 1'b1;
    @(negedge clk); perr_set = 1'b0;
    exp_ctrl[5] = 1'b1;
    rd_word(AW'(0), v); chk("R9 perr_set sets bit 5", v, exp_ctrl);

    // R8: write zero keeps, write one clears
    ctrl_write(32'h0000_0001, 1'b0);
    rd_word(AW'(0), v); chk("R8 bit5 kept by zero", v, exp_ctrl);
    ctrl_write(32'h0000_0020, 1'b0);
    rd_word(AW'(0), v); chk("R8 bit5 cleared by one", v, exp_ctrl);

    // R9: set wins over clear in the same cycle
    ctrl_write(32'h0000_0020, 1'b1);
    rd_word(AW'(0), v); chk("R9 set wins", v, exp_ctrl);
    chk("R9 flag", {31'h0, v[5]}, 32'h1);

    // R10: nonzero offset writes ignored
    for (int o = 1; o < 4; o++) begin
      wr_word(AW'(o), 2'd0, 32'hFFFF_FFFF, 1'b0);
      rd_word(AW'(0), v); chk("R10 offset write ignored", v, exp_ctrl);
    end

    // R11: break register is read-only
    wr_word(AW'(4), 2'd2, 32'h0, 1'b0);
    rd_word(AW'(4), v); chk("R11 break unchanged", v, 32'h80);
    chk("R11 halt_en", {31'h0, halt_en}, 32'h1);

    // R12: unmapped register words
    for (int w = 2; w < ROWS; w++) begin
      wr_word(AW'(w * 4), 2'd2, 32'hFFFF_FFFF, 1'b0);
      rd_word(AW'(w * 4), v); chk("R12 unmapped reads zero", v, 32'h0);
      rd_word(AW'(0), v); chk("R12 control untouched", v, exp_ctrl);
      rd_word(AW'(4), v); chk("R12 break untouched", v, 32'h80);
    end

    // R2: read in flight then idle
    cyc(1'b0, arr_addr(1, 0), 2'd2, 32'h0, 1'b0, v, vld);
    chk("R2 row1 data", v, exp_mem[1]);
    @(negedge clk);
    chk("R2 rvalid drops", {31'h0, bus_rvalid}, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R2 actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule